// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block holds the pending-interrupt flags and the interrupt enables of a general-purpose parallel-port and timer peripheral. The two timers and the serial shift unit raise single-cycle set pulses; each pulse latches a bit in a seven-bit flag register. Software masks the flags through a seven-bit enable register. The block drives one interrupt request line toward the processor.

Software sees both registers through the peripheral's register select and its read and write strobes. Reads are combinational and take their value from the registered state. Writes, and the clear that a read of the shift register causes, take effect at the next rising clock edge. Each written register uses its own write rule, and each read synthesises its own top bit, so that software can set or clear single bits without a read-modify-write sequence.

Top module: `irq_ctl`

## Requirements
- R1: After reset, both the flag register and the enable register are zero, the interrupt line is low, a flag read returns 0x00 and an enable read returns 0x80.
- R2: A set pulse on input bit k sets flag bit k at the next clock edge. The flag bits are: bit 2 for shift complete, bit 3 for shift data, bit 4 for shift clock, bit 5 for the second timer and bit 6 for the first timer.
- R3: The interrupt line is high exactly when some flag is both pending and enabled among bits 6, 5 and 2. Bits 0, 1, 3 and 4 never raise the line.
- R4: A read at select 0x0D returns the flags in bits 6:0, with bit 7 set when any of the seven flags is both pending and enabled.
- R5: A read at select 0x0E returns the enables in bits 6:0, and bit 7 always reads as one.
- R6: A write at select 0x0E with data bit 7 = 1 sets every enable bit whose data bit is one and leaves the other enable bits unchanged.
- R7: A write at select 0x0E with data bit 7 = 0 clears every enable bit whose data bit is one and leaves the other enable bits unchanged.
- R8: A write at select 0x0D clears every flag bit whose data bit is one and leaves the other flags unchanged. Data bit 7 is ignored.
- R9: A read at select 0x0A (the shift register) clears flag bits 2, 3 and 4 and leaves bits 0, 1, 5 and 6 unchanged.
- R10: When a set pulse and a clear (a flag write or a shift-register read) hit the same flag bit in the same cycle, the flag ends set.
- R11: A read at any other select returns 0x00. A write at any other select changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 4 | Register select |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| set_pulse | input | 7 | Per-flag set pulses from the timers and the shift unit |
| rd_data | output | 8 | Read data for the current select |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that a read strobe and a write strobe never arrive in the same cycle, and that strobes and set pulses are clean single-cycle values that change only between clock edges. The driver drives every input on the falling edge and issues only one access per cycle. The write checks compare against the set pulses of the same cycle, because a set pulse may overlap a clear, and the stimulus does overlap them on purpose to test which one wins.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int unsigned FLAG_W = 7;
    localparam int unsigned DATA_W = FLAG_W + 1;
    localparam int unsigned SEL_W  = 4;

    // register selects the block decodes
    localparam logic [SEL_W-1:0] SEL_SHIFT = 4'hA;
    localparam logic [SEL_W-1:0] SEL_FLAG  = 4'hD;
    localparam logic [SEL_W-1:0] SEL_ENA   = 4'hE;

    // flag positions
    localparam int unsigned BIT_SHDONE = 2;
    localparam int unsigned BIT_SHDATA = 3;
    localparam int unsigned BIT_SHCLK  = 4;
    localparam int unsigned BIT_TMR2   = 5;
    localparam int unsigned BIT_TMR1   = 6;

    // flags cleared by a shift register read
    localparam logic [FLAG_W-1:0] SHIFT_GROUP =
        (FLAG_W'(1) << BIT_SHDONE) | (FLAG_W'(1) << BIT_SHDATA) | (FLAG_W'(1) << BIT_SHCLK);

    // flags able to raise the request line
    localparam logic [FLAG_W-1:0] IRQ_SOURCES =
        (FLAG_W'(1) << BIT_TMR1) | (FLAG_W'(1) << BIT_TMR2) | (FLAG_W'(1) << BIT_SHDONE);

    typedef struct packed {
        logic [FLAG_W-1:0] bits;
    } flag_state_t;

    typedef struct packed {
        logic [FLAG_W-1:0] bits;
    } ena_state_t;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_ctl_pkg::*;
#(
    parameter logic [FLAG_W-1:0] RD_CLR_GROUP = SHIFT_GROUP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_pulse,
    input  logic              wr_clr,
    input  logic [FLAG_W-1:0] wr_mask,
    input  logic              rd_clr,
    output logic [FLAG_W-1:0] flag_q
);

    flag_state_t st_d, st_q;
    logic [FLAG_W-1:0] clr_vec;

    // per-bit clear request from the two clear sources
    for (genvar g = 0; g < int'(FLAG_W); g++) begin : g_clr
        if (RD_CLR_GROUP[g]) begin : g_grp
            assign clr_vec[g] = (wr_clr & wr_mask[g]) | rd_clr;
        end else begin : g_solo
            assign clr_vec[g] = wr_clr & wr_mask[g];
        end
    end

    always_comb begin
        st_d = st_q;
        st_d.bits = (st_q.bits & ~clr_vec) | set_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_q = st_q.bits;

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pulse != '0) |=> ((flag_q & $past(set_pulse)) == $past(set_pulse)));

    // R8
    flag_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((flag_q & $past(wr_mask) & ~$past(set_pulse)) == '0));

    // R9
    flag_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((flag_q & RD_CLR_GROUP & ~$past(set_pulse)) == '0));

    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_clr && !rd_clr && set_pulse == '0) |=> $stable(flag_q));

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [FLAG_W-1:0] en_q
);

    ena_state_t st_d, st_q;
    logic              set_mode;
    logic [FLAG_W-1:0] sel_bits;

    assign set_mode = wr_data[DATA_W-1];
    assign sel_bits = wr_data[FLAG_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (set_mode) st_d.bits = st_q.bits | sel_bits;
            else          st_d.bits = st_q.bits & ~sel_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q = st_q.bits;

    // R6
    ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && set_mode) |=>
            (((en_q & $past(sel_bits)) == $past(sel_bits)) &&
             ((en_q & ~$past(sel_bits)) == ($past(en_q) & ~$past(sel_bits)))));

    // R7
    ena_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !set_mode) |=>
            (((en_q & $past(sel_bits)) == '0) &&
             ((en_q & ~$past(sel_bits)) == ($past(en_q) & ~$past(sel_bits)))));

    // R11
    ena_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_ctl_pkg::*;
(
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [FLAG_W-1:0] flag_q,
    input  logic [FLAG_W-1:0] en_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    logic any_live;

    always_comb begin
        any_live = |(flag_q & en_q);
        irq      = |(flag_q & en_q & IRQ_SOURCES);
        unique case (reg_sel)
            SEL_FLAG: rd_data = {any_live, flag_q};
            SEL_ENA:  rd_data = {1'b1, en_q};
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] set_pulse,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    logic              flag_wr, ena_wr, shift_rd;
    logic [FLAG_W-1:0] flag_q, en_q;

    assign flag_wr  = wr_stb && (reg_sel == SEL_FLAG);
    assign ena_wr   = wr_stb && (reg_sel == SEL_ENA);
    assign shift_rd = rd_stb && (reg_sel == SEL_SHIFT);

    irq_flag_bank #(.RD_CLR_GROUP(SHIFT_GROUP)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (set_pulse),
        .wr_clr    (flag_wr),
        .wr_mask   (wr_data[FLAG_W-1:0]),
        .rd_clr    (shift_rd),
        .flag_q    (flag_q)
    );

    irq_enable_bank u_enables (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ena_wr),
        .wr_data (wr_data),
        .en_q    (en_q)
    );

    irq_read_mux u_rdmux (
        .reg_sel (reg_sel),
        .flag_q  (flag_q),
        .en_q    (en_q),
        .rd_data (rd_data),
        .irq     (irq)
    );

    // R3
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((en_q & IRQ_SOURCES) != '0));

    // R3
    irq_ignores_shift_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & IRQ_SOURCES) == '0) |-> !irq);

    // R5
    ena_read_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_ENA) |-> rd_data[DATA_W-1]);

    // R4
    flag_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_FLAG && irq) |-> rd_data[DATA_W-1]);

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && ((wr_data[FLAG_W-1:0] & set_pulse) != '0)) |=>
            ((flag_q & $past(set_pulse)) == $past(set_pulse)));

endmodule

// File: tb/irq_ctl_bench.sv
module irq_ctl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_sel = '0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [6:0] set_pulse = '0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] data;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    // bench model of the registers
    logic [6:0] m_flag = '0;
    logic [6:0] m_en   = '0;

    always #10 clk = ~clk;

    irq_ctl u_irq_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .set_pulse (set_pulse),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    function automatic logic [7:0] model_read(input logic [3:0] sel);
        case (sel)
            4'hD:    return {|(m_flag & m_en), m_flag};
            4'hE:    return {1'b1, m_en};
            default: return 8'h00;
        endcase
    endfunction

    // one access cycle; a read pushes its expected result
    task automatic access(input logic [3:0] sel, input bit rd, input bit wr,
                          input logic [7:0] d, input logic [6:0] set, input string tag);
        exp_t e;
        logic [6:0] nf;
        @(negedge clk);
        reg_sel = sel; rd_stb = rd; wr_stb = wr; wr_data = d; set_pulse = set;
        if (rd) begin
            e.data = model_read(sel);
            e.irq  = |(m_flag & m_en & 7'b1100100);
            e.tag  = tag;
            exp_q.push_back(e);
        end
        nf = m_flag;
        if (wr && sel == 4'hD) nf = nf & ~d[6:0];
        if (rd && sel == 4'hA) nf = nf & ~7'b0011100;
        nf = nf | set;
        m_flag = nf;
        if (wr && sel == 4'hE) m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
    endtask

    task automatic rd(input logic [3:0] sel, input string tag);
        access(sel, 1'b1, 1'b0, 8'h00, 7'h00, tag);
    endtask

    task automatic wr(input logic [3:0] sel, input logic [7:0] d, input string tag);
        access(sel, 1'b0, 1'b1, d, 7'h00, tag);
    endtask

    task automatic pulse(input logic [6:0] set, input string tag);
        access(4'h0, 1'b0, 1'b0, 8'h00, set, tag);
    endtask

    // monitor: compare in the middle of the low phase
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (rd_stb && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (rd_data !== e.data || irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s: rd_data=%02h irq=%0b expected rd_data=%02h irq=%0b",
                             e.tag, rd_data, irq, e.data, e.irq);
                end
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'hD, "R1 flags after reset");
        rd(4'hE, "R1 enables after reset");

        // R2 each source sets its own flag
        pulse(7'b1000000, "R2 timer1 set");
        rd(4'hD, "R2 timer1 flag bit6");
        pulse(7'b0100000, "R2 timer2 set");
        pulse(7'b0011100, "R2 shift group set");
        rd(4'hD, "R2 all source flags");

        // R4 summary without enables is clear; R3 irq low
        rd(4'hD, "R4 summary clear with no enables");

        // R6 set enable of shift-data only: summary up, irq stays low
        wr(4'hE, 8'h88, "R6 set enable bit3");
        rd(4'hE, "R6 enable bit3 read back");
        rd(4'hD, "R3 R4 bit3 enabled: summary set, irq low");

        // R6 enable timer1: irq rises
        wr(4'hE, 8'hC0, "R6 set enable bit6");
        rd(4'hE, "R5 R6 enables read back");
        rd(4'h0, "R3 irq high from timer1, R11 other read zero");

        // R7 clear enable bit6 only
        wr(4'hE, 8'h40, "R7 clear enable bit6");
        rd(4'hE, "R7 bit3 kept, bit6 cleared");
        rd(4'hD, "R3 irq low after enable clear");

        // R8 clear timer2 flag only, bit7 ignored
        wr(4'hD, 8'hA0, "R8 clear flag bit5");
        rd(4'hD, "R8 only bit5 cleared");

        // R9 shift register read clears group only
        wr(4'hE, 8'hA4, "R6 enable bits 5 and 2");
        rd(4'hD, "R3 irq high from shift done");
        rd(4'hA, "R9 shift read returns zero");
        rd(4'hD, "R9 shift group cleared, timer1 kept");

        // R10 set wins over flag write clear
        pulse(7'b0000100, "R10 prepare bit2");
        access(4'hD, 1'b0, 1'b1, 8'h44, 7'b0000100, "R10 write clear with set");
        rd(4'hD, "R10 bit2 stays set, bit6 cleared");
        // R10 set wins over shift-read clear
        access(4'hA, 1'b1, 1'b0, 8'h00, 7'b0001000, "R10 shift read with set");
        rd(4'hD, "R10 bit3 survives shift read");

        // R11 writes elsewhere are ignored
        wr(4'h3, 8'hFF, "R11 stray write");
        wr(4'hA, 8'h7F, "R11 write at shift select");
        rd(4'hD, "R11 flags unchanged");
        rd(4'hE, "R11 enables unchanged");

        // R2 low bits set and read back, R3 no irq from them
        wr(4'hE, 8'h7F, "R7 clear all enables");
        pulse(7'b0000011, "R2 low bits set");
        wr(4'hE, 8'h83, "R6 enable low bits");
        rd(4'hD, "R3 R4 low bits: summary set, irq low");

        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0; set_pulse = '0;
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule